// File: doc/BRIEF.md
# Timer Interrupt Router

This block sits between a bank of timers and an interrupt controller. For every timer it decides how an expiry is delivered. An expiry can go out as a message write to an address. It can go out as a one-clock pulse on a controller pin. It can also go out as a level that stays asserted on a pin until it is cleared. The block holds the configuration that drives this choice for each timer: the interrupt enable, the trigger type, the message enable and the pin route. It also holds a level-status bit per timer and the message register of each timer.

A global legacy-replacement input takes timers 0 and 1 away from their own routing. They go to fixed pins and are always edge triggered. Each configuration write is checked against a read-only mask of allowed pins. A write can also tear down a latched level that the new settings would otherwise leave stuck on the pin. Software-style acknowledgement clears level-status bits through a write-one-to-clear strobe. Message requests leave through a valid/ready handshake.

Top module: `tmr_irq_router`

## Requirements
- R1: With `legacy_en` high, an expiry of timer 0 pulses pin 2 and an expiry of timer 1 pulses pin 8. This holds whatever their message enable, trigger type or route, as long as the interrupt enable is set.
- R2: Message delivery is used only when the timer's message enable (config bit 14) is set and the timer is not under legacy override. A timer in message mode never touches a pin.
- R3: An expiry of a timer whose interrupt enable (config bit 2) is clear produces no pulse, no level and no message.
- R4: An enabled edge-mode timer (config bit 1 = 0) with a nonzero route (config bits 13:9) raises `pin_pulse` at the routed pin for exactly one cycle. The pulse appears in the cycle after the expiry strobe is sampled.
- R5: An enabled level-mode timer (config bit 1 = 1) sets its status bit and holds `pin_level` high at its pin. While that bit is set, further expiries of the timer are ignored.
- R6: An expiry that resolves to pin 0 is dropped.
- R7: A configuration write whose resolved pin is nonzero and missing from the allowed mask stores a route of 0. With 24 or more controller pins the mask allows pins 20 to 23; otherwise it allows none.
- R8: A configuration write clears a set status bit, and drops its level, in four cases: the interrupt is disabled, the mode becomes edge, the mode becomes message, or the pin changes. A write that keeps level mode on the same pin leaves the bit set.
- R9: A set bit in `stat_clr` clears that timer's status bit and releases its level on the next clock edge.
- R10: A message request drives address = message register bits 63:32 and data = bits 31:0. Valid, address and data are held until `msg_ready` is seen.
- R11: Message requests that are pending at the same time are issued lowest timer index first.
- R12: After reset, all pins are idle, every status bit is clear and no message is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| legacy_en | input | 1 | Legacy-replacement override for timers 0 and 1 |
| fire | input | NUM_TIMERS | One-cycle expiry strobe per timer |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_sel | input | IDX_W | Timer addressed by the configuration write |
| cfg_wr_data | input | 32 | Configuration word (bit 1 level, bit 2 enable, 13:9 route, 14 message enable) |
| msg_wr_en | input | 1 | Message register write strobe |
| msg_wr_sel | input | IDX_W | Timer addressed by the message register write |
| msg_wr_data | input | 64 | Message register value (63:32 address, 31:0 data) |
| stat_clr | input | NUM_TIMERS | Write-one-to-clear for status bits |
| msg_ready | input | 1 | Message sink accepts the current request |
| pin_level | output | 32 | Latched level per controller pin |
| pin_pulse | output | 32 | One-cycle edge pulse per controller pin |
| level_status | output | NUM_TIMERS | Per-timer level status bits |
| msg_valid | output | 1 | Message request valid |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |

## Verification
An expiry sampled at one clock edge shows its pulse, its level and its status bit right after that same edge. A message request shows up one edge later, because it first passes through the pending stage. A configuration write or status clear sampled at an edge drops the level right after that edge. The bench drives every input on the falling edge and samples on the following falling edges. It checks pins and status one sample after the strobe, and the message and the end of the pulse one sample later. A sweep covers every timer, both legacy settings, every enable/trigger/message combination and four routes.

// File: rtl/tmr_irq_pkg.sv
// Shared field positions, constants and types for the timer interrupt router.
package tmr_irq_pkg;

    localparam int ROUTE_W    = 5;
    localparam int PIN_SLOTS  = 1 << ROUTE_W;
    localparam int BIT_LEVEL  = 1;
    localparam int BIT_INT_EN = 2;
    localparam int ROUTE_LSB  = 9;
    localparam int BIT_MSG_EN = 14;

    localparam logic [ROUTE_W-1:0] LEG_PIN_T0 = 5'd2;
    localparam logic [ROUTE_W-1:0] LEG_PIN_T1 = 5'd8;

    // Writable per-timer settings
    typedef struct packed {
        logic               msg_en;
        logic [ROUTE_W-1:0] route;
        logic               int_en;
        logic               level;
    } tcfg_t;

    // Resolved delivery decision for one timer
    typedef struct packed {
        logic               legacy;
        logic               msg_act;
        logic               edge_mode;
        logic [ROUTE_W-1:0] pin;
    } tres_t;

    // Extract the writable fields from a configuration word
    function automatic tcfg_t unpack_cfg(input logic [31:0] w);
        tcfg_t c;
        c.msg_en = w[BIT_MSG_EN];
        c.route  = w[ROUTE_LSB +: ROUTE_W];
        c.int_en = w[BIT_INT_EN];
        c.level  = w[BIT_LEVEL];
        return c;
    endfunction

endpackage

// File: rtl/tmr_irq_resolve.sv
// Combinational delivery resolver for one timer.
// Turns settings, the legacy override and the timer index into message/pin/edge.
// Assumes the index is a valid timer number; legacy applies to indices 0 and 1.
module tmr_irq_resolve
    import tmr_irq_pkg::*;
#(
    parameter int IDX_W       = 3,
    parameter bit MSG_CAPABLE = 1'b1
) (
    input  tcfg_t            cfg,
    input  logic             legacy_en,
    input  logic [IDX_W-1:0] idx,
    output tres_t            res
);

    // Resolve the delivery path with legacy taking precedence
    always_comb begin
        res.legacy    = legacy_en && ((idx >> 1) == '0);
        res.msg_act   = MSG_CAPABLE && cfg.msg_en && !res.legacy;
        res.edge_mode = res.legacy || !cfg.level;
        if (res.msg_act)
            res.pin = '0;
        else if (res.legacy)
            res.pin = idx[0] ? LEG_PIN_T1 : LEG_PIN_T0;
        else
            res.pin = cfg.route;
    end

endmodule

// File: rtl/tmr_irq_pin_drive.sv
// Pin fan-out: ORs latched levels onto their pins and registers one-cycle pulses.
// Assumes callers only raise pulse_req for timers that resolved to a nonzero pin.
module tmr_irq_pin_drive
    import tmr_irq_pkg::*;
#(
    parameter int NUM_TIMERS = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [NUM_TIMERS-1:0]                level_on,
    input  logic [NUM_TIMERS-1:0][ROUTE_W-1:0]   level_pin,
    input  logic [NUM_TIMERS-1:0]                pulse_req,
    input  logic [NUM_TIMERS-1:0][ROUTE_W-1:0]   pulse_pin,
    output logic [PIN_SLOTS-1:0]                 pin_level,
    output logic [PIN_SLOTS-1:0]                 pin_pulse
);

    logic [PIN_SLOTS-1:0] pulse_nxt;
    logic [PIN_SLOTS-1:0] pulse_q;

    // Merge every latched timer onto its pin
    always_comb begin
        pin_level = '0;
        for (int i = 0; i < NUM_TIMERS; i++)
            if (level_on[i]) pin_level[level_pin[i]] = 1'b1;
    end

    // Decode this cycle's edge requests onto pins
    always_comb begin
        pulse_nxt = '0;
        for (int i = 0; i < NUM_TIMERS; i++)
            if (pulse_req[i]) pulse_nxt[pulse_pin[i]] = 1'b1;
    end

    // Register pulses so each lasts one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= '0;
        else        pulse_q <= pulse_nxt;
    end

    assign pin_pulse = pulse_q;

endmodule

// File: rtl/tmr_irq_msg_queue.sv
// Message request stage: one pending bit per timer, lowest index served first.
// Address and data come from the message register when a request is loaded.
// Output is held until the sink accepts it; repeat requests while pending merge.
module tmr_irq_msg_queue #(
    parameter int NUM_TIMERS = 8,
    localparam int IDX_W     = $clog2(NUM_TIMERS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_TIMERS-1:0]        req,
    input  logic [NUM_TIMERS-1:0][63:0]  msg_reg,
    input  logic                         ready,
    output logic                         valid,
    output logic [31:0]                  addr,
    output logic [31:0]                  data
);

    logic [NUM_TIMERS-1:0] pend_q;
    logic [NUM_TIMERS-1:0] gnt;
    logic [IDX_W-1:0]      gsel;
    logic                  slot_free;
    logic                  valid_q;
    logic [31:0]           addr_q;
    logic [31:0]           data_q;

    assign slot_free = !valid_q || ready;

    // Pick the lowest pending index
    always_comb begin
        gsel = '0;
        for (int i = NUM_TIMERS - 1; i >= 0; i--)
            if (pend_q[i]) gsel = IDX_W'(i);
        gnt = '0;
        if (slot_free && (pend_q != '0)) gnt[gsel] = 1'b1;
    end

    // Track pending requests
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~gnt) | req;
    end

    // Load or retire the outgoing request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
        end else if (slot_free) begin
            valid_q <= (pend_q != '0);
            if (pend_q != '0) begin
                addr_q <= msg_reg[gsel][63:32];
                data_q <= msg_reg[gsel][31:0];
            end
        end
    end

    assign valid = valid_q;
    assign addr  = addr_q;
    assign data  = data_q;

endmodule

// File: rtl/tmr_irq_router.sv
// Timer interrupt router top. Holds per-timer settings, message registers and
// level status bits. Turns expiry strobes into pin pulses, pin levels or
// message requests. Validates routes on every configuration write and drops
// stale levels. Assumes at most one configuration write per cycle, and no
// expiry of a timer in the same cycle as a write to that timer.
module tmr_irq_router
    import tmr_irq_pkg::*;
#(
    parameter int NUM_TIMERS = 8,
    parameter int CTRL_PINS  = 24,
    localparam int IDX_W     = $clog2(NUM_TIMERS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  legacy_en,
    input  logic [NUM_TIMERS-1:0] fire,
    input  logic                  cfg_wr_en,
    input  logic [IDX_W-1:0]      cfg_wr_sel,
    input  logic [31:0]           cfg_wr_data,
    input  logic                  msg_wr_en,
    input  logic [IDX_W-1:0]      msg_wr_sel,
    input  logic [63:0]           msg_wr_data,
    input  logic [NUM_TIMERS-1:0] stat_clr,
    input  logic                  msg_ready,
    output logic [31:0]           pin_level,
    output logic [31:0]           pin_pulse,
    output logic [NUM_TIMERS-1:0] level_status,
    output logic                  msg_valid,
    output logic [31:0]           msg_addr,
    output logic [31:0]           msg_data
);

    localparam logic [PIN_SLOTS-1:0] ALLOWED_PINS =
        (CTRL_PINS >= 24) ? PIN_SLOTS'(32'h00F0_0000) : '0;

    tcfg_t [NUM_TIMERS-1:0]               cfg_q;
    logic  [NUM_TIMERS-1:0][63:0]         msg_q;
    logic  [NUM_TIMERS-1:0]               status_q;
    logic  [NUM_TIMERS-1:0][ROUTE_W-1:0]  lvl_pin_q;
    tres_t [NUM_TIMERS-1:0]               res;
    logic  [NUM_TIMERS-1:0][ROUTE_W-1:0]  res_pin;
    logic  [NUM_TIMERS-1:0]               take;
    logic  [NUM_TIMERS-1:0]               msg_req;
    logic  [NUM_TIMERS-1:0]               pulse_req;
    logic  [NUM_TIMERS-1:0]               level_set;
    logic  [NUM_TIMERS-1:0]               wr_clr;
    logic  [NUM_TIMERS-1:0]               clr_any;

    tcfg_t              cand;
    tcfg_t              cand_fix;
    tres_t              wr_res;
    logic               wr_hit;
    logic               wr_bad;
    logic [ROUTE_W-1:0] fin_pin;
    logic               wr_drop_lvl;

    // Per-timer resolution and expiry decode
    for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tmr
        tmr_irq_resolve #(.IDX_W(IDX_W)) u_res (
            .cfg       (cfg_q[i]),
            .legacy_en (legacy_en),
            .idx       (IDX_W'(i)),
            .res       (res[i])
        );
        assign res_pin[i]   = res[i].pin;
        assign take[i]      = fire[i] && cfg_q[i].int_en && !status_q[i];
        assign msg_req[i]   = take[i] && res[i].msg_act;
        assign pulse_req[i] = take[i] && !res[i].msg_act && (res[i].pin != '0) && res[i].edge_mode;
        assign level_set[i] = take[i] && !res[i].msg_act && (res[i].pin != '0) && !res[i].edge_mode;
        assign wr_clr[i]    = wr_hit && (cfg_wr_sel == IDX_W'(i)) && status_q[i] && wr_drop_lvl;
        assign clr_any[i]   = (stat_clr[i] && status_q[i]) || wr_clr[i];
    end

    // Resolve the candidate settings of a configuration write
    assign cand   = unpack_cfg(cfg_wr_data);
    assign wr_hit = cfg_wr_en && (32'(cfg_wr_sel) < NUM_TIMERS);

    tmr_irq_resolve #(.IDX_W(IDX_W)) u_wr_res (
        .cfg       (cand),
        .legacy_en (legacy_en),
        .idx       (cfg_wr_sel),
        .res       (wr_res)
    );

    // Validate the route and decide whether a latched level must go
    always_comb begin
        wr_bad   = (wr_res.pin != '0) && !ALLOWED_PINS[wr_res.pin];
        cand_fix = cand;
        if (wr_bad) cand_fix.route = '0;
        fin_pin  = wr_bad ? (wr_res.legacy ? wr_res.pin : '0) : wr_res.pin;
        wr_drop_lvl = !cand.int_en || wr_res.msg_act || wr_res.edge_mode ||
                      (fin_pin != lvl_pin_q[cfg_wr_sel]);
    end

    // Store validated timer settings
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else if (wr_hit) cfg_q[cfg_wr_sel] <= cand_fix;
    end

    // Store message registers
    always_ff @(posedge clk) begin
        if (!rst_n) msg_q <= '0;
        else if (msg_wr_en && (32'(msg_wr_sel) < NUM_TIMERS)) msg_q[msg_wr_sel] <= msg_wr_data;
    end

    // Latch level status and remember the pin it drives
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q  <= '0;
            lvl_pin_q <= '0;
        end else begin
            for (int i = 0; i < NUM_TIMERS; i++) begin
                if (level_set[i]) begin
                    status_q[i]  <= 1'b1;
                    lvl_pin_q[i] <= res[i].pin;
                end else if (clr_any[i]) begin
                    status_q[i]  <= 1'b0;
                end
            end
        end
    end

    tmr_irq_pin_drive #(.NUM_TIMERS(NUM_TIMERS)) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .level_on  (status_q),
        .level_pin (lvl_pin_q),
        .pulse_req (pulse_req),
        .pulse_pin (res_pin),
        .pin_level (pin_level),
        .pin_pulse (pin_pulse)
    );

    tmr_irq_msg_queue #(.NUM_TIMERS(NUM_TIMERS)) u_msg (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (msg_req),
        .msg_reg (msg_q),
        .ready   (msg_ready),
        .valid   (msg_valid),
        .addr    (msg_addr),
        .data    (msg_data)
    );

    assign level_status = status_q;

endmodule

// File: rtl/tmr_irq_router_chk.sv
// Property checker for the timer interrupt router, bound to the top module.
// Observes ports plus the status and latched-pin state of the top.
module tmr_irq_router_chk #(
    parameter int NUM_TIMERS = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NUM_TIMERS-1:0]       fire,
    input logic [NUM_TIMERS-1:0]       stat_clr,
    input logic [NUM_TIMERS-1:0]       status,
    input logic [NUM_TIMERS-1:0][4:0]  lvl_pin,
    input logic [31:0]                 pin_level,
    input logic [31:0]                 pin_pulse,
    input logic                        msg_valid,
    input logic                        msg_ready,
    input logic [31:0]                 msg_addr,
    input logic [31:0]                 msg_data
);

    for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_lvl
        // R5
        level_pin_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
            status[i] |-> pin_level[lvl_pin[i]]);
    end

    // R3
    status_needs_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~$past(status) & ~$past(fire)) == '0));

    // R4
    pulse_from_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_pulse != '0) |-> ($past(fire) != '0));

    // R9
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & $past(stat_clr & status)) == '0));

    // R10
    msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

endmodule

bind tmr_irq_router tmr_irq_router_chk #(.NUM_TIMERS(NUM_TIMERS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .stat_clr  (stat_clr),
    .status    (status_q),
    .lvl_pin   (lvl_pin_q),
    .pin_level (pin_level),
    .pin_pulse (pin_pulse),
    .msg_valid (msg_valid),
    .msg_ready (msg_ready),
    .msg_addr  (msg_addr),
    .msg_data  (msg_data)
);

// File: tb/tmr_irq_router_test.sv
// Sweep bench for the timer interrupt router with an arithmetic delivery model.
module tmr_irq_router_test;

    localparam int CLK_PERIOD = 10;
    localparam int NT = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          legacy_en = 1'b0;
    logic [NT-1:0] fire = '0;
    logic          cfg_wr_en = 1'b0;
    logic [2:0]    cfg_wr_sel = '0;
    logic [31:0]   cfg_wr_data = '0;
    logic          msg_wr_en = 1'b0;
    logic [2:0]    msg_wr_sel = '0;
    logic [63:0]   msg_wr_data = '0;
    logic [NT-1:0] stat_clr = '0;
    logic          msg_ready = 1'b0;
    logic [31:0]   pin_level;
    logic [31:0]   pin_pulse;
    logic [NT-1:0] level_status;
    logic          msg_valid;
    logic [31:0]   msg_addr;
    logic [31:0]   msg_data;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tmr_irq_router uut (
        .clk(clk), .rst_n(rst_n), .legacy_en(legacy_en), .fire(fire),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel), .cfg_wr_data(cfg_wr_data),
        .msg_wr_en(msg_wr_en), .msg_wr_sel(msg_wr_sel), .msg_wr_data(msg_wr_data),
        .stat_clr(stat_clr), .msg_ready(msg_ready), .pin_level(pin_level),
        .pin_pulse(pin_pulse), .level_status(level_status), .msg_valid(msg_valid),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    function automatic logic [31:0] cw(input bit ie, input bit lv, input bit me, input int route);
        return (32'(lv) << 1) | (32'(ie) << 2) | (32'(route) << 9) | (32'(me) << 14);
    endfunction

    function automatic logic [31:0] exp_addr(input int t);
        return 32'hA000_0000 | 32'(t << 4);
    endfunction

    function automatic logic [31:0] exp_data(input int t);
        return 32'hD000_0000 | 32'(t);
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic write_cfg(input int t, input logic [31:0] w);
        cfg_wr_en = 1'b1; cfg_wr_sel = 3'(t); cfg_wr_data = w;
        tick();
        cfg_wr_en = 1'b0;
    endtask

    task automatic strobe(input logic [NT-1:0] m);
        fire = m;
        tick();
        fire = '0;
    endtask

    task automatic cleanup();
        stat_clr = '1; msg_ready = 1'b1;
        tick();
        stat_clr = '0; msg_ready = 1'b0;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        int routes[4] = '{0, 5, 20, 23};
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R12 reset state
        check("R12 pin_level", 64'(pin_level), 64'd0);
        check("R12 pin_pulse", 64'(pin_pulse), 64'd0);
        check("R12 status", 64'(level_status), 64'd0);
        check("R12 msg_valid", 64'(msg_valid), 64'd0);

        for (int t = 0; t < NT; t++) begin
            msg_wr_en = 1'b1; msg_wr_sel = 3'(t);
            msg_wr_data = {exp_addr(t), exp_data(t)};
            tick();
        end
        msg_wr_en = 1'b0;

        // Sweep: legacy x timer x enable/level/message x route
        for (int lg = 0; lg < 2; lg++) begin
            for (int t = 0; t < NT; t++) begin
                for (int cb = 0; cb < 8; cb++) begin
                    for (int ri = 0; ri < 4; ri++) begin
                        bit ie = cb[0];
                        bit lv = cb[1];
                        bit me = cb[2];
                        int route = routes[ri];
                        bit leg = (lg == 1) && (t < 2);
                        bit mact = me && !leg;
                        bit edg = leg || !lv;
                        bit zeroed = 1'b0;
                        int pin;
                        string tag;
                        logic [63:0] e_pulse;
                        logic [63:0] e_level;
                        logic [63:0] e_stat;
                        bit e_msg;
                        pin = mact ? 0 : (leg ? (t == 1 ? 8 : 2) : route);
                        if (pin != 0 && !(pin >= 20 && pin <= 23)) begin
                            zeroed = 1'b1;
                            if (!leg) pin = 0;
                        end
                        if (!ie)          tag = "R3";
                        else if (leg)     tag = "R1";
                        else if (mact)    tag = "R2";
                        else if (zeroed)  tag = "R7";
                        else if (pin == 0) tag = "R6";
                        else if (edg)     tag = "R4";
                        else              tag = "R5";
                        e_pulse = (ie && !mact && pin != 0 && edg)  ? (64'd1 << pin) : 64'd0;
                        e_level = (ie && !mact && pin != 0 && !edg) ? (64'd1 << pin) : 64'd0;
                        e_stat  = (e_level != 0) ? (64'd1 << t) : 64'd0;
                        e_msg   = ie && mact;

                        legacy_en = lg[0];
                        write_cfg(t, cw(ie, lv, me, route));
                        strobe(NT'(1) << t);
                        check({tag, " pulse"}, 64'(pin_pulse), e_pulse);
                        check({tag, " level"}, 64'(pin_level), e_level);
                        check({tag, " status"}, 64'(level_status), e_stat);
                        tick();
                        // R4 pulse lasts one cycle
                        check("R4 pulse width", 64'(pin_pulse), 64'd0);
                        check({tag, " msg_valid"}, 64'(msg_valid), 64'(e_msg));
                        if (e_msg) begin
                            check("R10 addr", 64'(msg_addr), 64'(exp_addr(t)));
                            check("R10 data", 64'(msg_data), 64'(exp_data(t)));
                            tick();
                            check("R10 held valid", 64'(msg_valid), 64'd1);
                            check("R10 held addr", 64'(msg_addr), 64'(exp_addr(t)));
                        end
                        cleanup();
                        // R9 clear releases level
                        check("R9 level after clear", 64'(pin_level), 64'd0);
                        check("R10 accepted", 64'(msg_valid), 64'd0);
                    end
                end
            end
        end
        legacy_en = 1'b0;

        // R5 repeat expiry while latched is ignored
        write_cfg(3, cw(1, 1, 0, 21));
        strobe(8'h08);
        check("R5 level set", 64'(pin_level), 64'd1 << 21);
        strobe(8'h08);
        check("R5 repeat no pulse", 64'(pin_pulse), 64'd0);
        check("R5 repeat level kept", 64'(pin_level), 64'd1 << 21);
        tick();
        check("R5 repeat no msg", 64'(msg_valid), 64'd0);

        // R8 unchanged level config keeps the bit
        write_cfg(3, cw(1, 1, 0, 21));
        check("R8 same config keeps", 64'(level_status), 64'h08);
        // R8 disable clears
        write_cfg(3, cw(0, 1, 0, 21));
        check("R8 disable clears level", 64'(pin_level), 64'd0);
        check("R8 disable clears status", 64'(level_status), 64'd0);
        // R8 switch to edge clears
        write_cfg(3, cw(1, 1, 0, 21));
        strobe(8'h08);
        write_cfg(3, cw(1, 0, 0, 21));
        check("R8 edge clears", 64'(pin_level), 64'd0);
        // R8 switch to message clears and issues nothing
        write_cfg(3, cw(1, 1, 0, 21));
        strobe(8'h08);
        write_cfg(3, cw(1, 1, 1, 21));
        check("R8 msg clears", 64'(pin_level), 64'd0);
        tick();
        tick();
        check("R8 msg no request", 64'(msg_valid), 64'd0);
        // R8 pin change clears, new pin used afterwards
        write_cfg(3, cw(1, 1, 0, 21));
        strobe(8'h08);
        write_cfg(3, cw(1, 1, 0, 22));
        check("R8 pin change clears", 64'(pin_level), 64'd0);
        strobe(8'h08);
        check("R8 new pin level", 64'(pin_level), 64'd1 << 22);
        cleanup();

        // R11 simultaneous messages, lowest index first
        write_cfg(2, cw(1, 0, 1, 0));
        write_cfg(5, cw(1, 0, 1, 0));
        msg_ready = 1'b1;
        strobe(8'h24);
        tick();
        check("R11 first valid", 64'(msg_valid), 64'd1);
        check("R11 first is timer 2", 64'(msg_data), 64'(exp_data(2)));
        tick();
        check("R11 second valid", 64'(msg_valid), 64'd1);
        check("R11 second is timer 5", 64'(msg_data), 64'(exp_data(5)));
        check("R11 second addr", 64'(msg_addr), 64'(exp_addr(5)));
        tick();
        check("R11 drained", 64'(msg_valid), 64'd0);
        msg_ready = 1'b0;

        finish_run();
    end

endmodule